// File: doc/BRIEF.md
# 16-bit Add Execute Unit

This block is the add-without-carry execute stage of a small 16-bit RISC coprocessor. It holds an eight-entry file of 16-bit registers and the N, Z, V and C condition flags. When `issue` is high it decodes one instruction word. If the word is an add, the block writes the destination register and the four flags at the next rising clock edge. If the word is anything else, it raises `illegal`.

There are two instruction forms. The three-register form adds two source registers. The byte-immediate forms add an 8-bit constant to the destination register, either into its low half or into its high half. Software builds a 16-bit immediate add by issuing the low-byte form and then the high-byte form. Each of the two steps computes its flags on its own, so no carry passes from the first step to the second. A read port (`rd_addr` and `rd_data`) exposes the register file. Register 0 always reads as zero.

Top module: `add16_exec`

## Requirements
- R1: When `instr[15:11]` = 00011 and `instr[1:0]` = 10, the word is the three-register add. Its fields are destination `instr[10:8]`, first source `instr[7:5]` and second source `instr[4:2]`. The destination receives the 16-bit sum of the two sources.
- R2: When `instr[15:11]` = 11100, the word is the low-byte immediate add. The destination `instr[10:8]` receives its old value plus the zero-extended byte `instr[7:0]`.
- R3: When `instr[15:11]` = 11101, the word is the high-byte immediate add. The destination `instr[10:8]` receives its old value plus the byte `instr[7:0]` placed in bits 15:8, with bits 7:0 zero.
- R4: After an add, N (`flags_nzvc[3]`) equals bit 15 of the result. Z (`flags_nzvc[2]`) is 1 exactly when the result is 0x0000.
- R5: After an add, V (`flags_nzvc[1]`) is 1 exactly when the signed two's-complement sum of the operands does not fit in 16 bits.
- R6: After an add, C (`flags_nzvc[0]`) is the carry out of bit 15 of the unsigned sum.
- R7: In a low-byte add followed by a high-byte add, the second step never uses the V or C produced by the first step. The flags after the pair reflect the second addition alone.
- R8: Register 0 always reads as zero, and writes to it are discarded. The flags are still updated when the destination is register 0.
- R9: When `issue` is high and the word matches none of the three encodings, `illegal` is high in that same cycle. The registers and flags stay unchanged.
- R10: A synchronous reset clears all registers and all flags to zero, and `illegal` is low while `issue` is low.
- R11: Each add completes in one cycle. The new register value and the new flags are visible after the first rising edge that follows the issue.
- R12: While `issue` is low, the registers and flags hold their values and `illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| rd_addr | input | 3 | Register file read address |
| rd_data | output | 16 | Register file read data |
| flags_nzvc | output | 4 | Condition flags: N, Z, V, C from bit 3 down to bit 0 |
| illegal | output | 1 | Issued word is not a recognised add |

## Verification
The assertions check the following on every cycle:
- Register 0 reads as zero.
- N and Z follow the result of each accepted add.
- A three-register add never raises `illegal`.
- The flags hold across an illegal word and across idle cycles.
- The flags are clear after reset.

The arithmetic itself can only be shown by the bench's scenarios, which compare against a model built on integers. These scenarios cover the following:
- The value of V and C at the signed and unsigned boundaries.
- The placement of the immediate byte in the low or high half.
- The loss of the low step's carry in a split 16-bit immediate.
- Discarded writes to register 0.

// File: rtl/add16_exec.sv
module add16_exec #(
  parameter int XLEN = 16,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue,
  input  logic [XLEN-1:0]         instr,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [XLEN-1:0]         rd_data,
  output logic [3:0]              flags_nzvc,
  output logic                    illegal
);
  localparam int AW = $clog2(NREG);
  localparam int HB = XLEN / 2;

  logic [XLEN-1:0] rf [NREG];
  logic [3:0]      flg;

  logic op_tri, op_lo, op_hi, legal;
  logic [AW-1:0] dst, src1, src2;
  logic [HB-1:0] imm;
  logic [XLEN-1:0] dst_val, s1_val, s2_val, opa, opb, res;
  logic [XLEN:0]   sum;
  logic v_new, c_new;

  assign op_tri = (instr[15:11] == 5'b00011) && (instr[1:0] == 2'b10);
  assign op_lo  = (instr[15:11] == 5'b11100);
  assign op_hi  = (instr[15:11] == 5'b11101);
  assign legal  = op_tri | op_lo | op_hi;
  assign illegal = issue & ~legal;

  assign dst  = instr[10:8];
  assign src1 = instr[7:5];
  assign src2 = instr[4:2];
  assign imm  = instr[HB-1:0];

  assign dst_val = (dst  == '0) ? '0 : rf[dst];
  assign s1_val  = (src1 == '0) ? '0 : rf[src1];
  assign s2_val  = (src2 == '0) ? '0 : rf[src2];
  assign rd_data = (rd_addr == '0) ? '0 : rf[rd_addr];

  always_comb begin
    if (op_tri) begin
      opa = s1_val;
      opb = s2_val;
    end else if (op_lo) begin
      opa = dst_val;
      opb = {{HB{1'b0}}, imm};
    end else begin
      opa = dst_val;
      opb = {imm, {HB{1'b0}}};
    end
  end

  assign sum   = {1'b0, opa} + {1'b0, opb};
  assign res   = sum[XLEN-1:0];
  assign v_new = (opa[XLEN-1] & opb[XLEN-1] & ~res[XLEN-1]) |
                 (~opa[XLEN-1] & ~opb[XLEN-1] & res[XLEN-1]);
  assign c_new = (opa[XLEN-1] & opb[XLEN-1]) | (opa[XLEN-1] & ~res[XLEN-1]) |
                 (opb[XLEN-1] & ~res[XLEN-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      flg <= '0;
    end else if (issue && legal) begin
      if (dst != '0) rf[dst] <= res;
      flg <= {res[XLEN-1], (res == '0), v_new, c_new};
    end
  end

  assign flags_nzvc = flg;
endmodule

module add16_exec_chk #(
  parameter int XLEN = 16,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            issue,
  input logic [XLEN-1:0] instr,
  input logic [AW-1:0]   rd_addr,
  input logic [XLEN-1:0] rd_data,
  input logic [3:0]      flags_nzvc,
  input logic            illegal,
  input logic [XLEN-1:0] res
);
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_addr == '0) |-> (rd_data == '0)); // R8
  AST_N_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (rst) (issue && !illegal) |=> (flags_nzvc[3] == $past(res[XLEN-1]))); // R4
  AST_Z_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (rst) (issue && !illegal) |=> (flags_nzvc[2] == ($past(res) == '0))); // R4
  AST_TRI_IS_LEGAL: assert property (@(posedge clk) disable iff (rst) (issue && instr[15:11] == 5'b00011 && instr[1:0] == 2'b10) |-> !illegal); // R1
  AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst) illegal |=> $stable(flags_nzvc)); // R9
  AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst) !issue |=> $stable(flags_nzvc)); // R12
  AST_IDLE_NOT_ILLEGAL: assert property (@(posedge clk) !issue |-> !illegal); // R12
  AST_RESET_CLEARS_FLAGS: assert property (@(posedge clk) $past(rst) |-> (flags_nzvc == 4'b0000)); // R10
endmodule

bind add16_exec add16_exec_chk #(.XLEN(XLEN), .AW(AW)) i_chk (
  .clk(clk), .rst(rst), .issue(issue), .instr(instr), .rd_addr(rd_addr),
  .rd_data(rd_data), .flags_nzvc(flags_nzvc), .illegal(illegal), .res(res)
);

// File: tb/test_add16_exec.sv
module test_add16_exec;
  logic clk = 0;
  logic rst = 1;
  logic issue = 0;
  logic [15:0] instr = '0;
  logic [2:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0] flags_nzvc;
  logic illegal;

  int tests = 0;
  int fails = 0;
  int mreg [8];
  int mflg = 0;

  add16_exec i_add16_exec (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr), .rd_addr(rd_addr),
    .rd_data(rd_data), .flags_nzvc(flags_nzvc), .illegal(illegal)
  );

  always #2 clk = ~clk;

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tri_w(int d, int a, int b);
    return {5'b00011, 3'(d), 3'(a), 3'(b), 2'b10};
  endfunction
  function automatic logic [15:0] lo_w(int d, int k);
    return {5'b11100, 3'(d), 8'(k)};
  endfunction
  function automatic logic [15:0] hi_w(int d, int k);
    return {5'b11101, 3'(d), 8'(k)};
  endfunction

  task automatic model(input logic [15:0] w, output bit ok, output int dst);
    int a, b, s, sa, sb, ss, res;
    ok = 1;
    dst = w[10:8];
    if (w[15:11] == 5'b00011 && w[1:0] == 2'b10) begin
      a = mreg[w[7:5]]; b = mreg[w[4:2]];
    end else if (w[15:11] == 5'b11100) begin
      a = mreg[dst]; b = w[7:0];
    end else if (w[15:11] == 5'b11101) begin
      a = mreg[dst]; b = w[7:0] * 256;
    end else begin
      ok = 0;
      return;
    end
    s = a + b;
    res = s % 65536;
    sa = (a >= 32768) ? a - 65536 : a;
    sb = (b >= 32768) ? b - 65536 : b;
    ss = sa + sb;
    mflg = ((res >= 32768) ? 8 : 0) + ((res == 0) ? 4 : 0) +
           ((ss > 32767 || ss < -32768) ? 2 : 0) + ((s >= 65536) ? 1 : 0);
    if (dst != 0) mreg[dst] = res;
  endtask

  task automatic exec(input logic [15:0] w, input string req);
    bit ok;
    int d;
    @(negedge clk);
    issue = 1; instr = w;
    #1;
    model(w, ok, d);
    check({req, " illegal"}, illegal, ok ? 0 : 1);
    @(negedge clk);
    issue = 0; instr = 16'hFFFF;
    rd_addr = 3'(d);
    #1;
    check({req, " R11 dest"}, rd_data, mreg[d]);
    check({req, " R11 flags"}, flags_nzvc, mflg);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_addr = 3'(i);
      #1;
      check(req, rd_data, mreg[i]);
      check({req, " R12 idle flags"}, flags_nzvc, mflg);
      check({req, " R12 idle illegal"}, illegal, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    read_all("R10 reset");
    exec(lo_w(1, 8'hFF), "R2 low imm");
    exec(hi_w(1, 8'h7F), "R3 high imm");
    exec(lo_w(2, 8'h01), "R2 low imm");
    exec(tri_w(3, 1, 2), "R1 tri 0x7FFF+1 R5");
    check("R5 V on signed overflow", flags_nzvc[1], 1);
    check("R4 N set", flags_nzvc[3], 1);
    exec(tri_w(4, 3, 3), "R1 tri 0x8000+0x8000 R6");
    check("R6 C carry out", flags_nzvc[0], 1);
    check("R4 Z zero result", flags_nzvc[2], 1);
    exec(lo_w(5, 8'hFF), "R2 low imm");
    exec(hi_w(5, 8'hFF), "R3 high imm");
    exec(lo_w(5, 8'h01), "R7 split low");
    check("R7 low step carry", flags_nzvc[0], 1);
    exec(hi_w(5, 8'h00), "R7 split high");
    check("R7 high step ignores carry", flags_nzvc, 4'b0100);
    check("R7 value", rd_data, 0);
    exec(lo_w(0, 8'h80), "R8 write r0");
    exec(tri_w(0, 1, 1), "R8 tri into r0");
    check("R8 flags on r0 dest", flags_nzvc, 4'b1010);
    exec(16'h0000, "R9 illegal zero word");
    exec(16'h1801, "R9 illegal tri low bits");
    exec(16'hF000, "R9 illegal top code");
    exec(tri_w(6, 2, 0), "R8 r0 source");
    for (int k = 0; k < 40; k++) begin
      int ch;
      ch = (k * 7 + 3) % 4;
      if (ch == 0) exec(tri_w((k % 7) + 1, k % 8, (k * 3) % 8), "R1 sweep");
      else if (ch == 1) exec(lo_w(k % 8, (k * 37) % 256), "R2 sweep");
      else if (ch == 2) exec(hi_w(k % 8, (k * 53) % 256), "R3 sweep");
      else exec(16'(k * 1237), "R9 sweep");
    end
    read_all("R12 final state");
    @(negedge clk);
    rst = 1;
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    mflg = 0;
    @(negedge clk);
    rst = 0;
    read_all("R10 second reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule